// File: doc/BRIEF.md
# Interrupt Pending and Wake-up Controller

This block turns interrupt events into pending bits and gates them with a mask. It then presents the CPU with a single request and the vector index of the winning source. There are four external pins, one nonmaskable pin, a set of internal request lines and a four-bit capture-overrun group. The overrun group has its own pending and mask registers and joins the main controller as one shared source. The CPU can also raise two always-enabled exception sources: a software trap and an unimplemented opcode.

The external pins and the nonmaskable pin are synchronized first. In normal and idle operation, a pin is sampled only while the phase-2 indicator is high. In standby and powerdown the CPU clocks are stopped, so sampling happens on every cycle. A rising edge of the sampled copy records one event.

The block also decides when a power-saving mode ends. It drives a resume signal together with one of two outcomes:
- service: take the interrupt.
- continue: proceed with the instruction after the one that entered the power-saving mode.

Software reads and writes the mask and pending registers over a small register bus. The write path is registered and the read path is combinational.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset, all four registers read 0 and irq and resume are low.
- R2: In normal or idle mode, a rising edge on ext_pin[i] sets main pending bit i (register address 1), but only when it is seen in a cycle with ph2 high. A pulse that never overlaps a ph2-high cycle sets nothing. A pin held high produces one event: after software clears the bit, it stays clear.
- R3: A rising edge on nmi_pin raises vector NSRC+2 (11 by default) whatever the mask contents. This vector outranks every other source, and an acknowledge clears it.
- R4: trap_req and badop_req pulses set always-enabled pending flags. Their vectors are NSRC (9) and NSRC+1 (10). The priority order is nonmaskable, then unimplemented opcode, then trap, then the maskable sources.
- R5: The maskable request vector is the pending bits ANDed with the mask register (address 0). Bits 0..3 are the external pins, bits 4..4+N_INT-1 are the internal lines (int_req[j] sets bit 4+j), and bit NMAIN (8) is the overrun summary. The highest set index wins, and irq_vec equals that index.
- R6: The overrun pending register (address 3) is set by ovr_req and gated by the overrun mask (address 2). Any unmasked set bit requests source NMAIN, which reads back as bit NMAIN of address 1.
- R7: An ack clears the pending bit of the vector presented in that cycle. Acknowledging the overrun source leaves the overrun pending register unchanged.
- R8: A write to address 1 loads the pending bits, so 1 sets and 0 clears. A hardware set in the same cycle wins over a software clear.
- R9: Mode codes are 0 normal, 1 idle, 2 standby and 3 powerdown. In modes 2 and 3, a high ext_pin[i] with ext_sfi[i]=1 drives resume whether or not the source is masked, and no ph2 is required. With ext_sfi[i]=0 the pin does not drive resume.
- R10: While resume is high, service is high if an enabled request is present and cont is high otherwise. The two are never high together.
- R11: In idle, resume is high exactly when an enabled request is present. In normal mode resume stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ph2 | input | 1 | High during clock phase 2 |
| pm | input | 2 | Power mode code |
| ext_pin | input | N_EXT | External interrupt pins |
| ext_sfi | input | N_EXT | Pin configured as special-function input |
| nmi_pin | input | 1 | Nonmaskable interrupt pin |
| int_req | input | N_INT | Internal request pulses |
| ovr_req | input | N_OVR | Capture-overrun set pulses |
| trap_req | input | 1 | Software trap pulse |
| badop_req | input | 1 | Unimplemented opcode pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | NSRC | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | NSRC | Read data |
| ack | input | 1 | CPU acknowledge of the presented vector |
| irq | output | 1 | Interrupt request |
| irq_vec | output | VW | Vector index of the winner |
| resume | output | 1 | Leave the power-saving mode |
| service | output | 1 | Resume and take the interrupt |
| cont | output | 1 | Resume and continue execution |

## Verification
The bench uses the default sizes: four external pins, four internal lines and four overrun bits. This gives eight main pending bits, so every one of the 256 pending patterns can be driven against several mask patterns, and the winning index is computed arithmetically. The 16-by-16 overrun pending and mask space is covered in full. Every combination of power mode, pin, configuration nibble and enable bit is walked for the standby and powerdown wake rule.

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl #(
  parameter int N_EXT = 4,
  parameter int N_INT = 4,
  parameter int N_OVR = 4,
  localparam int NMAIN = N_EXT + N_INT,
  localparam int NSRC = NMAIN + 1,
  localparam int VW = $clog2(NSRC + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ph2,
  input  logic [1:0]       pm,
  input  logic [N_EXT-1:0] ext_pin,
  input  logic [N_EXT-1:0] ext_sfi,
  input  logic             nmi_pin,
  input  logic [N_INT-1:0] int_req,
  input  logic [N_OVR-1:0] ovr_req,
  input  logic             trap_req,
  input  logic             badop_req,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [NSRC-1:0]  wr_data,
  input  logic [1:0]       rd_addr,
  output logic [NSRC-1:0]  rd_data,
  input  logic             ack,
  output logic             irq,
  output logic [VW-1:0]    irq_vec,
  output logic             resume,
  output logic             service,
  output logic             cont
);
  localparam logic [VW-1:0] V_TRAP  = VW'(NSRC);
  localparam logic [VW-1:0] V_BADOP = VW'(NSRC + 1);
  localparam logic [VW-1:0] V_NMI   = VW'(NSRC + 2);

  logic [N_EXT:0] sync1, sync2, smp;
  logic [NMAIN-1:0] pend, ack_clr;
  logic [NSRC-1:0]  mask;
  logic [N_OVR-1:0] ovr_pend, ovr_mask;
  logic nmi_p, trap_p, bad_p;
  logic sel_hit;
  logic [VW-1:0] sel_idx;

  wire lowpwr = pm[1];
  wire upd = ph2 | lowpwr;
  wire [N_EXT:0] pin_rise = upd ? (sync2 & ~smp) : '0;
  wire [NMAIN-1:0] hw_set = {int_req, pin_rise[N_EXT-1:0]};
  wire ovr_any = |(ovr_pend & ovr_mask);
  wire [NSRC-1:0] req = {ovr_any, pend} & mask;
  wire exc_any = nmi_p | bad_p | trap_p;
  wire ack_main = ack & ~exc_any & sel_hit;

  wire wr_mask = wr_en && wr_addr == 2'd0;
  wire wr_pend = wr_en && wr_addr == 2'd1;
  wire wr_omsk = wr_en && wr_addr == 2'd2;
  wire wr_opnd = wr_en && wr_addr == 2'd3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      smp   <= '0;
    end else begin
      sync1 <= {nmi_pin, ext_pin};
      sync2 <= sync1;
      if (upd) smp <= sync2;
    end

  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (req[i]) begin
        sel_hit = 1'b1;
        sel_idx = VW'(i);
      end
    for (int i = 0; i < NMAIN; i++)
      ack_clr[i] = ack_main && sel_idx == VW'(i);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend     <= '0;
      mask     <= '0;
      ovr_pend <= '0;
      ovr_mask <= '0;
      nmi_p    <= 1'b0;
      trap_p   <= 1'b0;
      bad_p    <= 1'b0;
    end else begin
      pend     <= (wr_pend ? wr_data[NMAIN-1:0] : (pend & ~ack_clr)) | hw_set;
      if (wr_mask) mask <= wr_data;
      if (wr_omsk) ovr_mask <= wr_data[N_OVR-1:0];
      ovr_pend <= (wr_opnd ? wr_data[N_OVR-1:0] : ovr_pend) | ovr_req;
      nmi_p    <= pin_rise[N_EXT] | (nmi_p & ~ack);
      bad_p    <= badop_req | (bad_p & ~(ack & ~nmi_p));
      trap_p   <= trap_req | (trap_p & ~(ack & ~nmi_p & ~bad_p));
    end

  always_comb begin
    if (nmi_p)       irq_vec = V_NMI;
    else if (bad_p)  irq_vec = V_BADOP;
    else if (trap_p) irq_vec = V_TRAP;
    else             irq_vec = sel_idx;
  end

  assign irq = exc_any | sel_hit;

  always_comb
    case (rd_addr)
      2'd0:    rd_data = mask;
      2'd1:    rd_data = {ovr_any, pend};
      2'd2:    rd_data = NSRC'(ovr_mask);
      default: rd_data = NSRC'(ovr_pend);
    endcase

  always_comb
    case (pm)
      2'd0:    resume = 1'b0;
      2'd1:    resume = irq;
      default: resume = |(smp[N_EXT-1:0] & ext_sfi);
    endcase

  assign service = resume & irq;
  assign cont    = resume & ~irq;
endmodule

// File: rtl/irq_wake_ctrl_chk.sv
module irq_wake_ctrl_chk #(
  parameter int N_EXT = 4,
  parameter int NMAIN = 8,
  parameter int NSRC = 9,
  parameter int VW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ph2,
  input logic [1:0]       pm,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             irq,
  input logic [VW-1:0]    irq_vec,
  input logic             resume,
  input logic             service,
  input logic             cont,
  input logic             nmi_p,
  input logic             trap_p,
  input logic             bad_p,
  input logic             ovr_any,
  input logic [NMAIN-1:0] pend,
  input logic [NSRC-1:0]  mask
);
  wire [NSRC-1:0] live = {ovr_any, pend} & mask;

  AST_EXT_PHASE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ph2 && !pm[1] && !(wr_en && wr_addr == 2'd1))
      |=> ((pend[N_EXT-1:0] & ~$past(pend[N_EXT-1:0])) == '0)); // R2

  AST_NMI_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_p |-> (irq && irq_vec == VW'(NSRC + 2))); // R3

  AST_EXC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_p && !nmi_p) |-> (irq_vec == VW'(NSRC + 1))); // R4

  AST_VEC_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_vec < VW'(NSRC)) |-> live[irq_vec]); // R5

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_p && !trap_p && !bad_p && live == '0) |-> !irq); // R5

  AST_WAKE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (service != cont)); // R10

  AST_CONT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cont |-> !irq); // R10

  AST_NORMAL_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (pm == 2'd0) |-> !resume); // R11

  AST_IDLE_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (pm == 2'd1 && irq) |-> service); // R11
endmodule

bind irq_wake_ctrl irq_wake_ctrl_chk #(
  .N_EXT(N_EXT), .NMAIN(NMAIN), .NSRC(NSRC), .VW(VW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ph2(ph2), .pm(pm), .wr_en(wr_en),
  .wr_addr(wr_addr), .irq(irq), .irq_vec(irq_vec), .resume(resume),
  .service(service), .cont(cont), .nmi_p(nmi_p), .trap_p(trap_p),
  .bad_p(bad_p), .ovr_any(ovr_any), .pend(pend), .mask(mask)
);

// File: tb/irq_wake_ctrl_tb.sv
module irq_wake_ctrl_tb;
  localparam int NSRC = 9;
  localparam int VW = 4;

  logic clk = 0, rst_n = 0, ph2 = 0, ph_run = 0;
  logic [1:0] pm = 0;
  logic [3:0] ext_pin = 0, ext_sfi = 0, int_req = 0, ovr_req = 0;
  logic nmi_pin = 0, trap_req = 0, badop_req = 0, wr_en = 0, ack = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [NSRC-1:0] wr_data = 0, rd_data;
  logic irq, resume, service, cont;
  logic [VW-1:0] irq_vec;
  int n_chk = 0, n_fail = 0;

  irq_wake_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ph2(ph2), .pm(pm), .ext_pin(ext_pin),
    .ext_sfi(ext_sfi), .nmi_pin(nmi_pin), .int_req(int_req), .ovr_req(ovr_req),
    .trap_req(trap_req), .badop_req(badop_req), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ack(ack),
    .irq(irq), .irq_vec(irq_vec), .resume(resume), .service(service), .cont(cont)
  );

  always #4 clk = ~clk;
  always @(negedge clk) ph2 <= ph_run ? ~ph2 : 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = NSRC'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    #1;
  endtask

  function automatic int top_bit(input int v);
    int r = -1;
    for (int b = 0; b < 16; b++) if (v[b]) r = b;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    ph_run = 1;
    cyc(2);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R1 reg", v, 0); end
    chk("R1 irq", int'(irq), 0);
    chk("R1 resume", int'(resume), 0);

    // R2 edge on each pin sets one pending bit, held level gives one event
    for (int i = 0; i < 4; i++) begin
      wr(1, 0);
      ext_pin[i] = 1;
      cyc(8);
      rd(1, v); chk("R2 edge", v, 1 << i);
      wr(1, 0);
      cyc(8);
      rd(1, v); chk("R2 held level once", v, 0);
      ext_pin[i] = 0;
      cyc(4);
    end
    // R2 pulse without any ph2 cycle is missed
    ph_run = 0; cyc(2);
    ext_pin[2] = 1; cyc(3); ext_pin[2] = 0; cyc(5);
    ph_run = 1; cyc(6);
    rd(1, v); chk("R2 no ph2", v, 0);

    // R5 priority sweep over all pending patterns
    for (int p = 0; p < 256; p++) begin
      int masks[6] = '{255, 15, 240, 170, 85, 0};
      foreach (masks[k]) begin
        int h;
        wr(0, masks[k]);
        wr(1, p);
        #1;
        h = p & masks[k];
        chk("R5 irq", int'(irq), int'(h != 0));
        if (h != 0) chk("R5 vec", int'(irq_vec), top_bit(h));
      end
    end
    // R5 internal lines land on bits 4+j
    for (int j = 0; j < 4; j++) begin
      wr(1, 0);
      @(negedge clk); int_req[j] = 1;
      @(negedge clk); int_req[j] = 0;
      rd(1, v); chk("R5 internal line", v, 1 << (4 + j));
    end

    // R8 software set and hardware-over-clear
    wr(1, 'h22); rd(1, v); chk("R8 write set", v, 'h22);
    @(negedge clk); wr_en = 1; wr_addr = 1; wr_data = 0; int_req[0] = 1;
    @(negedge clk); wr_en = 0; int_req[0] = 0;
    rd(1, v); chk("R8 hw wins", v, 'h10);

    // R7 ack clears presented bit
    wr(0, 'hFF); wr(1, 'h81); #1;
    chk("R7 vec before", int'(irq_vec), 7);
    do_ack();
    rd(1, v); chk("R7 cleared", v, 'h01);
    chk("R7 next vec", int'(irq_vec), 0);

    // R3 nmi ignores mask
    wr(0, 0); wr(1, 'h80); #1;
    chk("R3 masked quiet", int'(irq), 0);
    nmi_pin = 1; cyc(4); nmi_pin = 0; cyc(6);
    chk("R3 nmi irq", int'(irq), 1);
    chk("R3 nmi vec", int'(irq_vec), 11);
    do_ack();
    chk("R3 nmi acked", int'(irq), 0);

    // R4 exception ordering
    wr(0, 'hFF);
    @(negedge clk); trap_req = 1; badop_req = 1;
    @(negedge clk); trap_req = 0; badop_req = 0; #1;
    chk("R4 badop vec", int'(irq_vec), 10);
    do_ack();
    chk("R4 trap vec", int'(irq_vec), 9);
    do_ack();
    chk("R4 maskable after", int'(irq_vec), 7);
    do_ack();
    rd(1, v); chk("R4 all clear", v, 0);

    // R6 overrun sweep
    wr(0, 'h100);
    for (int p = 0; p < 16; p++)
      for (int m = 0; m < 16; m++) begin
        wr(2, m); wr(3, p);
        chk("R6 irq", int'(irq), int'((p & m) != 0));
        if ((p & m) != 0) chk("R6 vec", int'(irq_vec), 8);
        rd(1, v); chk("R6 summary bit", v, ((p & m) != 0) ? 'h100 : 0);
      end
    wr(3, 0); wr(2, 'hF);
    @(negedge clk); ovr_req = 4'b0100;
    @(negedge clk); ovr_req = 0;
    rd(3, v); chk("R6 hw set", v, 4);
    do_ack();
    rd(3, v); chk("R7 overrun ack keeps", v, 4);
    wr(3, 0); wr(2, 0);

    // R9/R10 standby and powerdown wake
    ph_run = 0;
    for (int md = 2; md < 4; md++) begin
      pm = 2'(md);
      for (int i = 0; i < 4; i++)
        for (int s = 0; s < 16; s++)
          for (int en = 0; en < 2; en++) begin
            ext_sfi = 4'(s);
            wr(1, 0); wr(0, en << i);
            ext_pin[i] = 1; cyc(5); #1;
            chk("R9 resume", int'(resume), s >> i & 1);
            chk("R10 service", int'(service), (s >> i & 1) & en);
            chk("R10 cont", int'(cont), (s >> i & 1) & (1 - en));
            rd(1, v); chk("R9 pend", v, 1 << i);
            ext_pin[i] = 0; cyc(4);
          end
    end

    // R11 idle and normal
    ph_run = 1; pm = 1; ext_sfi = 0;
    wr(0, 0); wr(1, 'h02); #1;
    chk("R11 idle masked", int'(resume), 0);
    wr(0, 'h02); #1;
    chk("R11 idle resume", int'(resume), 1);
    chk("R11 idle service", int'(service), 1);
    chk("R11 idle cont", int'(cont), 0);
    pm = 0; #1;
    chk("R11 normal no resume", int'(resume), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule